// File: doc/BRIEF.md
# Minterm OR Array

This block is a small programmable logic element of the PROM kind. A fixed decode plane turns a 4-bit input word into its 16 minterms, exactly one of which is active at any time. A programmable OR plane then forms four outputs. Each output ORs together any subset of the 16 minterms that its 16-bit enable mask selects, so any output can carry any Boolean function of the four inputs. For example, 4-input parity needs the eight odd-weight minterms.

The 64 enable bits sit in a configuration register. A parallel write port loads one output's whole 16-bit mask per clock edge. The path from the data inputs to the outputs is purely combinational, so a configured array acts like a lookup logic cone. A cleared enable removes its minterm from the sum, and a cleared mask drives its output low.

Top module: `mintermOrArray`

## Requirements
- R1: While `rstN` is low, all four masks clear to zero. After reset, every output reads 0 for all 16 input values until a mask is written.
- R2: Input `dataIn[3]` is the most significant bit of the minterm index and `dataIn[0]` is the least significant, so the active minterm index k equals the unsigned value of `dataIn`.
- R3: Output `dataOut[o]` is 1 exactly when bit k of mask o is 1, where k is the current value of `dataIn`.
- R4: When `cfgWrEn` is high at a rising edge of `clk`, `cfgMask` is stored as the mask of the output selected by `cfgSel` (0 to 3). The other three masks keep their values.
- R5: When `cfgWrEn` is low at a rising edge, no mask changes, whatever `cfgSel` and `cfgMask` carry.
- R6: An output whose mask is 16'h0000 is constant 0 for all inputs. An output whose mask is 16'hFFFF is constant 1 for all inputs.
- R7: The mask 16'h6996 (minterms 1, 2, 4, 7, 8, 11, 13, 14) makes that output the XOR of all four inputs.
- R8: Outputs follow a change of `dataIn` with no clock edge in between. There is no register on the data path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rstN | input | 1 | Active-low synchronous reset; clears all masks |
| cfgWrEn | input | 1 | Mask write enable |
| cfgSel | input | 2 | Index of the output whose mask is written |
| cfgMask | input | 16 | New mask; bit k enables minterm k |
| dataIn | input | 4 | Logic inputs; bit 3 is the MSB of the minterm index |
| dataOut | output | 4 | OR-plane outputs |

## Verification
The hardest case to reach is a write that lands on one output while the other three hold distinct, non-trivial masks. A fault that corrupts a neighbour's mask shows only when that neighbour is probed at the one minterm where its old and new contents differ. For this reason the stimulus keeps all four masks live under random values, issues writes to random outputs (some with the enable low), and after every write sweeps all 16 input values on all four outputs. Directed single-minterm masks pin down the bit ordering of the index. The all-clear, all-set and parity masks cover the remaining corners.

// File: rtl/mintermOrPkg.sv
package mintermOrPkg;
  localparam int IN_W   = 4;
  localparam int OUT_N  = 4;
  localparam int TERM_N = 1 << IN_W;
  localparam int SEL_W  = $clog2(OUT_N);

  typedef struct packed {
    logic [OUT_N-1:0]  load;
    logic [TERM_N-1:0] mask;
  } cfgStrobe_t;
endpackage

// File: rtl/mintermOrCtrl.sv
module mintermOrCtrl
  import mintermOrPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  sel,
  input  logic [TERM_N-1:0] mask,
  output cfgStrobe_t        strobe
);

  always_comb begin
    strobe.mask = mask;
    strobe.load = '0;
    if (wrEn) strobe.load[sel] = 1'b1;
  end

  // R4
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.load));

  // R5
  idle_no_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (strobe.load == '0));

  // R4
  write_hits_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> ($countones(strobe.load) == 1));

endmodule

// File: rtl/mintermOrPath.sv
module mintermOrPath
  import mintermOrPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cfgStrobe_t       strobe,
  input  logic [IN_W-1:0]  dataIn,
  output logic [OUT_N-1:0] dataOut
);

  logic [TERM_N-1:0] termHot;
  logic [TERM_N-1:0] maskQ [OUT_N];

  // fixed AND plane: one line per minterm index
  for (genvar t = 0; t < TERM_N; t++) begin : g_term
    assign termHot[t] = (dataIn == IN_W'(t));
  end

  // R2
  single_term_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(termHot) == 1);

  for (genvar o = 0; o < OUT_N; o++) begin : g_out
    always_ff @(posedge clk) begin
      if (!rstN)                maskQ[o] <= '0;
      else if (strobe.load[o])  maskQ[o] <= strobe.mask;
    end

    assign dataOut[o] = |(termHot & maskQ[o]);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$past(rstN) |-> (maskQ[o] == '0));

    // R4
    load_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.load[o] |=> (maskQ[o] == $past(strobe.mask)));

    // R5
    hold_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.load[o] |=> $stable(maskQ[o]));

    // R6
    empty_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      (maskQ[o] == '0) |-> !dataOut[o]);

    // R6
    full_high_chk: assert property (@(posedge clk) disable iff (!rstN)
      (&maskQ[o]) |-> dataOut[o]);
  end

endmodule

// File: rtl/mintermOrArray.sv
module mintermOrArray
  import mintermOrPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [TERM_N-1:0] cfgMask,
  input  logic [IN_W-1:0]   dataIn,
  output logic [OUT_N-1:0]  dataOut
);

  cfgStrobe_t strobe;

  mintermOrCtrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (cfgWrEn),
    .sel    (cfgSel),
    .mask   (cfgMask),
    .strobe (strobe)
  );

  mintermOrPath path_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

endmodule

// File: tb/mintermOrArray_tb.sv
module mintermOrArray_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [15:0] cfgMask = '0;
  logic [3:0]  dataIn = '0;
  logic [3:0]  dataOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] expMask [4];

  always #10 clk = ~clk;

  mintermOrArray dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgMask(cfgMask), .dataIn(dataIn), .dataOut(dataOut)
  );

  function automatic logic expBit(logic [15:0] m, logic [3:0] v);
    return m[v];
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%b exp=%b", req, act, exp);
    end
  endtask

  // writes at negedge, captured at the next rising edge
  task automatic cfgWrite(logic en, logic [1:0] sel, logic [15:0] m);
    @(negedge clk);
    cfgWrEn = en; cfgSel = sel; cfgMask = m;
    @(posedge clk);
    #1;
    cfgWrEn = 1'b0;
    if (en) expMask[sel] = m;
  endtask

  // sweep without clock involvement: combinational path (R8)
  task automatic sweep(string req);
    for (int v = 0; v < 16; v++) begin
      dataIn = 4'(v);
      #1;
      for (int o = 0; o < 4; o++)
        check(req, dataOut[o], expBit(expMask[o], 4'(v)));
    end
  endtask

  initial begin
    for (int o = 0; o < 4; o++) expMask[o] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    sweep("R1 reset clear");

    // R2: single-minterm masks locate the index ordering
    cfgWrite(1'b1, 2'd0, 16'h0100);
    cfgWrite(1'b1, 2'd1, 16'h0002);
    cfgWrite(1'b1, 2'd2, 16'h0008);
    cfgWrite(1'b1, 2'd3, 16'h8000);
    dataIn = 4'b1000; #1;
    check("R2 input1 is MSB", dataOut[0], 1'b1);
    dataIn = 4'b0001; #1;
    check("R2 input4 is LSB", dataOut[1], 1'b1);
    sweep("R2 index order");

    // R6 corners
    cfgWrite(1'b1, 2'd1, 16'h0000);
    cfgWrite(1'b1, 2'd2, 16'hFFFF);
    sweep("R6 empty/full masks");

    // R7 parity
    cfgWrite(1'b1, 2'd3, 16'h6996);
    for (int v = 0; v < 16; v++) begin
      dataIn = 4'(v); #1;
      check("R7 parity", dataOut[3], ^(4'(v)));
    end

    // R5 disabled write leaves all masks alone
    cfgWrite(1'b0, 2'd3, 16'h0000);
    cfgWrite(1'b0, 2'd2, 16'h0000);
    sweep("R5 write disabled");

    // R3/R4 constrained random
    void'($urandom(32'd4711));
    for (int i = 0; i < 60; i++) begin
      logic en;
      en = ($urandom % 4) != 0;
      cfgWrite(en, 2'($urandom % 4), 16'($urandom));
      sweep(en ? "R3 R4 random write" : "R5 random idle");
    end

    // R1 again: reset mid-run
    @(negedge clk); rstN = 1'b0;
    @(posedge clk); #1;
    @(negedge clk); rstN = 1'b1;
    for (int o = 0; o < 4; o++) expMask[o] = '0;
    #1;
    sweep("R1 reset after use");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule